// File: doc/BRIEF.md
# MSI Event Queue Ring Controller

This block turns routed message-signalled interrupts into records in a set of circular queues held in host memory. Each incoming event already names its target queue. The block checks that the queue is enabled, healthy and not full. It then builds a 64-byte self-describing record and issues it as one memory write at the slot that the queue's tail pointer selects. After the write it advances the tail.

Software owns the head pointer. It reads records from the head, zeroes the format/type field of each slot it frees, and writes the new head back. A queue keeps raising its interrupt line for as long as it is enabled and holds unread records.

Each queue has a small register set: a control register that sets bits, a control register that clears bits, a state register, a tail register and a head register. One shared register holds the queue base address. When a queue fills, the incoming record is dropped, a sticky overflow flag is set and the queue moves to an error state. Software recovers it through the clear register.

Top module: `msiq_ring_ctrl`

## Requirements
- R1: After reset every queue is disabled and idle (state reads 1), head and tail read 0, overflow is clear, every irq bit is low and mem_wr_valid is low.
- R2: A register is selected by reg_addr = {queue, sel}, where sel 0 is control-set, 1 control-clear, 2 state, 3 tail, 4 head and 5 base. Writing control-set with bit 44 enables the queue and bit 57 forces the overflow flag. Writing control-clear with bit 44 disables the queue. Both control registers read back the enable in bit 44 and the overflow flag in bit 57.
- R3: The state register holds a one-hot code in bits 2:0. It reads 4 (error) while the error condition is held, otherwise 2 (active) while the queue is enabled, otherwise 1 (idle).
- R4: An accepted event produces, in the cycle after it is presented, exactly one mem_wr_valid pulse. The write address is base + queue*8192 + tail*64, where base keeps bits 49:6 of the written value and address bits 63:50 are zero.
- R5: Word 0 of the record (mem_wr_w0) is: bit 63 zero, bits 62:56 ev_fmt, 55:46 ev_len, 45:32 ev_addr[61:48], 31:16 ev_rid, 15:0 ev_data[15:0]. The six words after word 1 are zero and are not driven.
- R6: Word 1 (mem_wr_w1) carries ev_addr[47:0] in bits 63:16 and ev_data[31:16] in bits 15:0.
- R7: Each accepted record advances the 7-bit tail by one, and the tail wraps from 127 to 0.
- R8: An event that arrives when tail+1 (mod 128) equals head is dropped with no memory write. The overflow flag then sets and stays set until control-clear is written with bit 57, and the queue enters the error state.
- R9: While in the error state a queue drops every event. Writing control-clear with bit 47 leaves the error state and leaves the overflow flag as it is.
- R10: A disabled queue drops events and leaves its pointers unchanged.
- R11: irq[q] is high exactly while queue q is enabled and its head differs from its tail.
- R12: The tail register reads the overflow flag in bit 57 and the tail in bits 6:0. The head register reads and writes the head in bits 6:0. The base register reads back bits 49:6 of the stored base with bits 63:50 forced to ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | {queue index, register select}; also selects the read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| ev_valid | input | 1 | Routed interrupt event present this cycle |
| ev_queue | input | 2 | Target queue of the event |
| ev_fmt | input | 7 | Format/type code of the event |
| ev_len | input | 10 | Length field |
| ev_rid | input | 16 | Requester ID |
| ev_addr | input | 62 | Message address bits |
| ev_data | input | 32 | Message data |
| mem_wr_valid | output | 1 | Record write issued this cycle |
| mem_wr_addr | output | 64 | Byte address of the record slot |
| mem_wr_w0 | output | 64 | Record word 0 |
| mem_wr_w1 | output | 64 | Record word 1 |
| irq | output | 4 | Per-queue interrupt, one bit per queue |

## Verification
The bench walks the tail across the 127-to-0 wrap and checks the slot address on both sides of it. A design that carried the wrap into the queue index would write into the neighbouring queue. It fills a queue to one slot short of the head and expects the next event to be dropped with the flag set. An off-by-one in the full test would overwrite the oldest unread record or lose a free slot.

It then frees space and checks that the queue still refuses records until the error state is cleared. It also checks that the bit-47 and bit-57 clears act independently. A design that tied them together would resume silently with the overflow history lost.

Disabled queues, the one-hot state code and the field positions of both record words are checked under directed cases and under seeded random traffic across all queues.

// File: rtl/msiq_pkg.sv
package msiq_pkg;

    localparam int REC_SHIFT   = 6;    // 64-byte records
    localparam int BASE_LO     = 6;    // base keeps bits 49:6
    localparam int BASE_HI     = 49;
    localparam int PHYS_W      = 50;
    localparam int EN_BIT      = 44;
    localparam int ERRCLR_BIT  = 47;
    localparam int OVF_BIT     = 57;

    typedef enum logic [2:0] {
        SEL_CTL_SET = 3'd0,
        SEL_CTL_CLR = 3'd1,
        SEL_STATE   = 3'd2,
        SEL_TAIL    = 3'd3,
        SEL_HEAD    = 3'd4,
        SEL_BASE    = 3'd5
    } reg_sel_e;

    typedef enum logic [2:0] {
        QS_IDLE   = 3'b001,
        QS_ACTIVE = 3'b010,
        QS_ERROR  = 3'b100
    } qstate_e;

    typedef struct packed {
        logic [6:0]  fmt;
        logic [9:0]  len;
        logic [15:0] rid;
        logic [61:0] addr;
        logic [31:0] data;
    } msi_event_t;

    function automatic logic [63:0] pack_word0(msi_event_t e);
        return {1'b0, e.fmt, e.len, e.addr[61:48], e.rid, e.data[15:0]};
    endfunction

    function automatic logic [63:0] pack_word1(msi_event_t e);
        return {e.addr[47:0], e.data[31:16]};
    endfunction

    function automatic qstate_e state_code(logic en, logic err);
        if (err)
            return QS_ERROR;
        else if (en)
            return QS_ACTIVE;
        else
            return QS_IDLE;
    endfunction

endpackage

// File: rtl/msiq_queue_ctx.sv
module msiq_queue_ctx
    import msiq_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             drop,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic             set_ovf,
    input  logic             clr_ovf,
    input  logic             clr_err,
    input  logic             head_we,
    input  logic             tail_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    output logic             en,
    output logic             ovf,
    output logic             err,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            ovf  <= 1'b0;
            err  <= 1'b0;
            head <= '0;
            tail <= '0;
        end else begin
            if (set_en)
                en <= 1'b1;
            else if (clr_en)
                en <= 1'b0;

            if (drop || set_ovf)
                ovf <= 1'b1;
            else if (clr_ovf)
                ovf <= 1'b0;

            if (drop)
                err <= 1'b1;
            else if (clr_err)
                err <= 1'b0;

            if (head_we)
                head <= ptr_wdata;

            if (tail_we)
                tail <= ptr_wdata;
            else if (push)
                tail <= tail + 1'b1;
        end
    end

    // R10
    push_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (en && !err));

    // R8
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (PTR_W'(tail + 1'b1) != head));

    // R7
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !tail_we) |=> (tail == PTR_W'($past(tail) + 1'b1)));

    // R8
    drop_flags_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> (ovf && err));

endmodule

// File: rtl/msiq_rec_fmt.sv
module msiq_rec_fmt
    import msiq_pkg::*;
#(
    parameter int QW    = 2,
    parameter int PTR_W = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fire,
    input  logic [QW-1:0]            queue,
    input  logic [PTR_W-1:0]         tail,
    input  logic [BASE_HI:BASE_LO]   base_hi,
    input  msi_event_t               ev,
    output logic                     wr_valid,
    output logic [63:0]              wr_addr,
    output logic [63:0]              wr_w0,
    output logic [63:0]              wr_w1
);

    localparam int SLOT_W = QW + PTR_W + REC_SHIFT;

    logic [PHYS_W-1:0] slot_off;
    logic [PHYS_W-1:0] slot_addr;

    always_comb begin
        slot_off  = PHYS_W'({queue, tail, {REC_SHIFT{1'b0}}});
        slot_addr = {base_hi, {BASE_LO{1'b0}}} + slot_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_w0    <= '0;
            wr_w1    <= '0;
        end else begin
            wr_valid <= fire;
            if (fire) begin
                wr_addr <= {{(64-PHYS_W){1'b0}}, slot_addr};
                wr_w0   <= pack_word0(ev);
                wr_w1   <= pack_word1(ev);
            end
        end
    end

    // R4
    rec_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[REC_SHIFT-1:0] == '0 && wr_addr[63:PHYS_W] == '0));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(fire));

    initial begin
        assert (SLOT_W <= PHYS_W);
    end

endmodule

// File: rtl/msiq_ring_ctrl.sv
module msiq_ring_ctrl
    import msiq_pkg::*;
#(
    parameter int NUM_Q = 4,
    parameter int PTR_W = 7,
    localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int AW   = QW + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              ev_valid,
    input  logic [QW-1:0]     ev_queue,
    input  logic [6:0]        ev_fmt,
    input  logic [9:0]        ev_len,
    input  logic [15:0]       ev_rid,
    input  logic [61:0]       ev_addr,
    input  logic [31:0]       ev_data,
    output logic              mem_wr_valid,
    output logic [63:0]       mem_wr_addr,
    output logic [63:0]       mem_wr_w0,
    output logic [63:0]       mem_wr_w1,
    output logic [NUM_Q-1:0]  irq
);

    logic [QW-1:0] acc_q;
    reg_sel_e      acc_sel;
    assign acc_q   = reg_addr[AW-1:3];
    assign acc_sel = reg_sel_e'(reg_addr[2:0]);

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata;

    logic [BASE_HI:BASE_LO] base_hi;
    always_ff @(posedge clk) begin
        if (rst)
            base_hi <= '0;
        else if (reg_we && acc_sel == SEL_BASE)
            base_hi <= reg_wdata[BASE_HI:BASE_LO];
    end

    logic [NUM_Q-1:0] en_a, ovf_a, err_a, push_a, drop_a;
    logic [PTR_W-1:0] head_a [NUM_Q];
    logic [PTR_W-1:0] tail_a [NUM_Q];
    qstate_e          state_a [NUM_Q];

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        logic hit, set_wr, clr_wr, full;
        assign hit    = reg_we && (acc_q == QW'(q));
        assign set_wr = hit && acc_sel == SEL_CTL_SET;
        assign clr_wr = hit && acc_sel == SEL_CTL_CLR;
        assign full   = (PTR_W'(tail_a[q] + 1'b1) == head_a[q]);

        always_comb begin
            push_a[q] = 1'b0;
            drop_a[q] = 1'b0;
            if (ev_valid && ev_queue == QW'(q) && en_a[q] && !err_a[q]) begin
                push_a[q] = !full;
                drop_a[q] = full;
            end
        end

        msiq_queue_ctx #(.PTR_W(PTR_W)) u_ctx (
            .clk       (clk),
            .rst       (rst),
            .push      (push_a[q]),
            .drop      (drop_a[q]),
            .set_en    (set_wr && reg_wdata[EN_BIT]),
            .clr_en    (clr_wr && reg_wdata[EN_BIT]),
            .set_ovf   (set_wr && reg_wdata[OVF_BIT]),
            .clr_ovf   (clr_wr && reg_wdata[OVF_BIT]),
            .clr_err   (clr_wr && reg_wdata[ERRCLR_BIT]),
            .head_we   (hit && acc_sel == SEL_HEAD),
            .tail_we   (hit && acc_sel == SEL_TAIL),
            .ptr_wdata (reg_wdata[PTR_W-1:0]),
            .en        (en_a[q]),
            .ovf       (ovf_a[q]),
            .err       (err_a[q]),
            .head      (head_a[q]),
            .tail      (tail_a[q])
        );

        assign state_a[q] = state_code(en_a[q], err_a[q]);
        assign irq[q]     = en_a[q] && (head_a[q] != tail_a[q]);

        // R3
        state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot(state_a[q]));

        // R10
        idle_queue_frozen_chk: assert property (@(posedge clk) disable iff (rst)
            (ev_valid && ev_queue == QW'(q) && !en_a[q] && !reg_we)
                |=> $stable(tail_a[q]));

        // R11
        irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
            (head_a[q] == tail_a[q]) |-> !irq[q]);
    end

    logic [PTR_W-1:0] ev_tail;
    always_comb begin
        ev_tail = '0;
        for (int q = 0; q < NUM_Q; q++)
            if (ev_queue == QW'(q))
                ev_tail = tail_a[q];
    end

    msi_event_t ev;
    assign ev = '{fmt: ev_fmt, len: ev_len, rid: ev_rid, addr: ev_addr, data: ev_data};

    msiq_rec_fmt #(.QW(QW), .PTR_W(PTR_W)) u_fmt (
        .clk      (clk),
        .rst      (rst),
        .fire     (|push_a),
        .queue    (ev_queue),
        .tail     (ev_tail),
        .base_hi  (base_hi),
        .ev       (ev),
        .wr_valid (mem_wr_valid),
        .wr_addr  (mem_wr_addr),
        .wr_w0    (mem_wr_w0),
        .wr_w1    (mem_wr_w1)
    );

    always_comb begin
        reg_rdata = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (acc_q == QW'(q)) begin
                case (acc_sel)
                    SEL_CTL_SET, SEL_CTL_CLR: begin
                        reg_rdata[EN_BIT]  = en_a[q];
                        reg_rdata[OVF_BIT] = ovf_a[q];
                    end
                    SEL_STATE: reg_rdata[2:0] = state_a[q];
                    SEL_TAIL: begin
                        reg_rdata[OVF_BIT]     = ovf_a[q];
                        reg_rdata[PTR_W-1:0]   = tail_a[q];
                    end
                    SEL_HEAD:  reg_rdata[PTR_W-1:0] = head_a[q];
                    default:   reg_rdata = '0;
                endcase
            end
        end
        if (acc_sel == SEL_BASE)
            reg_rdata = {{(64-PHYS_W){1'b1}}, base_hi, {BASE_LO{1'b0}}};
    end

endmodule

// File: tb/msiq_ring_ctrl_bench.sv
module msiq_ring_ctrl_bench;

    localparam int NQ = 4;
    localparam int PW = 7;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        ev_valid;
    logic [1:0]  ev_queue;
    logic [6:0]  ev_fmt;
    logic [9:0]  ev_len;
    logic [15:0] ev_rid;
    logic [61:0] ev_addr;
    logic [31:0] ev_data;
    logic        mem_wr_valid;
    logic [63:0] mem_wr_addr, mem_wr_w0, mem_wr_w1;
    logic [NQ-1:0] irq;

    always #2.5 clk = ~clk;

    msiq_ring_ctrl #(.NUM_Q(NQ), .PTR_W(PW)) u_msiq_ring_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_queue(ev_queue), .ev_fmt(ev_fmt), .ev_len(ev_len), .ev_rid(ev_rid),
        .ev_addr(ev_addr), .ev_data(ev_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_addr(mem_wr_addr), .mem_wr_w0(mem_wr_w0), .mem_wr_w1(mem_wr_w1),
        .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit        m_en [NQ];
    bit        m_ovf[NQ];
    bit        m_err[NQ];
    int        m_head[NQ];
    int        m_tail[NQ];
    logic [63:0] m_base;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_w0(logic [6:0] f, logic [9:0] l,
                                          logic [61:0] a, logic [15:0] r, logic [31:0] d);
        logic [63:0] w = '0;
        w[62:56] = f; w[55:46] = l; w[45:32] = a[61:48];
        w[31:16] = r; w[15:0] = d[15:0];
        return w;
    endfunction

    function automatic logic [63:0] exp_w1(logic [61:0] a, logic [31:0] d);
        return {a[47:0], d[31:16]};
    endfunction

    function automatic logic [2:0] exp_state(int q);
        return m_err[q] ? 3'd4 : (m_en[q] ? 3'd2 : 3'd1);
    endfunction

    task automatic wr_reg(int q, int sel, logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {2'(q), 3'(sel)}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            0: begin if (d[44]) m_en[q] = 1; if (d[57]) m_ovf[q] = 1; end
            1: begin if (d[44]) m_en[q] = 0; if (d[57]) m_ovf[q] = 0; if (d[47]) m_err[q] = 0; end
            3: m_tail[q] = int'(d[6:0]);
            4: m_head[q] = int'(d[6:0]);
            5: m_base = {14'd0, d[49:6], 6'd0};
            default: ;
        endcase
    endtask

    task automatic rd_reg(int q, int sel, output logic [63:0] d);
        @(negedge clk);
        reg_addr = {2'(q), 3'(sel)};
        #1 d = reg_rdata;
    endtask

    task automatic check_q(string req, int q);
        logic [63:0] d;
        logic [63:0] t;
        rd_reg(q, 2, d);
        chk(req, $sformatf("state q%0d", q), d, {61'd0, exp_state(q)});
        rd_reg(q, 3, d);
        t = 64'(m_tail[q]); t[57] = m_ovf[q];
        chk(req, $sformatf("tail q%0d", q), d, t);
        rd_reg(q, 4, d);
        chk(req, $sformatf("head q%0d", q), d, 64'(m_head[q]));
        chk("R11", $sformatf("irq q%0d", q), 64'(irq[q]),
            64'(m_en[q] && (m_head[q] != m_tail[q])));
    endtask

    task automatic send_ev(string req, int q, logic [6:0] f, logic [9:0] l,
                           logic [61:0] a, logic [15:0] r, logic [31:0] d);
        bit open, full;
        logic [63:0] eaddr;
        open = m_en[q] && !m_err[q];
        full = ((m_tail[q] + 1) % DEPTH) == m_head[q];
        eaddr = m_base + 64'(q) * 64'd8192 + 64'(m_tail[q]) * 64'd64;
        @(negedge clk);
        ev_valid = 1'b1; ev_queue = 2'(q); ev_fmt = f; ev_len = l;
        ev_addr = a; ev_rid = r; ev_data = d;
        @(negedge clk);
        ev_valid = 1'b0;
        chk(req, "write pulse", 64'(mem_wr_valid), 64'(open && !full));
        if (open && !full) begin
            chk("R4", "slot address", mem_wr_addr, eaddr);
            chk("R5", "word0", mem_wr_w0, exp_w0(f, l, a, r, d));
            chk("R6", "word1", mem_wr_w1, exp_w1(a, d));
            m_tail[q] = (m_tail[q] + 1) % DEPTH;
        end else if (open && full) begin
            m_ovf[q] = 1; m_err[q] = 1;
        end
    endtask

    task automatic rand_ev(string req, int q);
        send_ev(req, q, 7'($urandom_range(1, 127)), 10'($urandom),
                {30'($urandom), 32'($urandom)}, 16'($urandom), 32'($urandom));
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        int seed_hold;
        seed_hold = $urandom(32'h5EED_0042);
        rst = 1'b1; reg_we = 0; reg_addr = 0; reg_wdata = 0; ev_valid = 0;
        ev_queue = 0; ev_fmt = 0; ev_len = 0; ev_rid = 0; ev_addr = 0; ev_data = 0;
        for (int q = 0; q < NQ; q++) begin
            m_en[q] = 0; m_ovf[q] = 0; m_err[q] = 0; m_head[q] = 0; m_tail[q] = 0;
        end
        m_base = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "mem_wr_valid", 64'(mem_wr_valid), 64'd0);
        chk("R1", "irq", 64'(irq), 64'd0);
        for (int q = 0; q < NQ; q++) check_q("R1", q);

        // R12 base readback with upper ones
        wr_reg(0, 5, 64'hFFFC_0000_0012_3440);
        rd_reg(2, 5, d);
        chk("R12", "base readback", d, 64'hFFFC_0000_0012_3440);

        // R10 disabled queue drops
        rand_ev("R10", 1);
        check_q("R10", 1);

        // R2 enable all
        for (int q = 0; q < NQ; q++) wr_reg(q, 0, 64'h1 << 44);
        rd_reg(2, 0, d);
        chk("R2", "ctl enable readback", d, 64'h1 << 44);
        for (int q = 0; q < NQ; q++) check_q("R3", q);

        // R4 R5 R6 directed records
        send_ev("R4", 0, 7'h58, 10'h3FF, 62'h2ABC_0000_1234_5678, 16'hBEEF, 32'hCAFE_F00D);
        send_ev("R4", 2, 7'h7B, 10'h001, 62'h0001_FFFF_FFFF_FFFF, 16'h0102, 32'h8000_0001);
        check_q("R11", 0);
        check_q("R11", 2);

        // R7 wrap
        wr_reg(3, 3, 64'd126);
        wr_reg(3, 4, 64'd126);
        check_q("R11", 3);
        rand_ev("R7", 3);
        rand_ev("R7", 3);
        check_q("R7", 3);
        chk("R7", "tail wrapped", 64'(m_tail[3]), 64'd0);

        // R8 overflow
        wr_reg(1, 3, 64'd9);
        wr_reg(1, 4, 64'd10);
        rand_ev("R8", 1);
        check_q("R8", 1);
        rd_reg(1, 1, d);
        chk("R8", "ctl ovf readback", d, (64'h1 << 44) | (64'h1 << 57));

        // R9 error state drops even with room
        wr_reg(1, 4, 64'd20);
        rand_ev("R9", 1);
        check_q("R9", 1);
        wr_reg(1, 1, 64'h1 << 47);
        check_q("R9", 1);
        rand_ev("R9", 1);
        check_q("R9", 1);
        wr_reg(1, 1, 64'h1 << 57);
        check_q("R8", 1);

        // R2 forced overflow and disable
        wr_reg(2, 0, 64'h1 << 57);
        check_q("R2", 2);
        wr_reg(2, 1, 64'h1 << 57);
        wr_reg(0, 1, 64'h1 << 44);
        check_q("R2", 0);
        rand_ev("R10", 0);
        check_q("R10", 0);
        wr_reg(0, 0, 64'h1 << 44);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            int q;
            q = int'($urandom_range(0, NQ - 1));
            if ($urandom_range(0, 5) == 0) begin
                wr_reg(q, 4, 64'(m_tail[q]));
                check_q("R11", q);
            end else begin
                rand_ev("R4", q);
            end
        end
        for (int q = 0; q < NQ; q++) check_q("R7", q);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule